// File: doc/BRIEF.md
# Serial-Flash Operation Command Sequencer

This block turns one serial-flash operation descriptor into the ordered list of 32-bit command entries that a generic-FIFO quad-SPI engine consumes. A descriptor names an opcode, up to four address bytes, a count of dummy bytes, a data length and a transfer direction. Each of the opcode, address, dummy and data phases carries its own lane width. The sequencer frames the operation with chip-select assert and deassert entries. It sends address bytes one per entry, converts dummy bytes into clock counts, and breaks long data lengths into power-of-two exponent entries followed by an immediate remainder.

Descriptors arrive on a valid/ready input. Entries leave on a valid/ready output, one per accepted handshake. The sequencer takes a new descriptor only when it has finished the previous one. It raises a one-cycle done pulse once the closing deassert entry has been accepted. The payload bytes themselves and any DMA movement belong to other blocks.

Entry fields are fixed because the engine decodes them: immediate in bits 7:0, data-transfer flag bit 8, exponent flag bit 9, lane mode bits 11:10, lower chip select bit 12, lower bus select bit 14, transmit bit 16, receive bit 17.

Top module: `qspi_op_sequencer`

## Requirements
- R1: `descReady` is high only while the sequencer is idle (no entry pending). A descriptor offered while busy is ignored, and after reset the block is idle with `entryValid` and `opDone` low.
- R2: Entries of one operation leave in this order: chip-select assert, opcode, address bytes, optional dummy entry, data entries, chip-select deassert. Nothing else is emitted.
- R3: The assert entry is 0x00005405: bus and chip select set, single-lane mode, hold count 5. The deassert entry is 0x00004005: bus select set, chip select clear, mode 00, hold count 5. Mode 00 appears on no other entry.
- R4: The opcode entry is 0x00015000 | mode<<10 | opcode, where mode is the command lane mode.
- R5: Each address byte goes in its own transmit entry (0x00015000 | mode<<10 | byte), most significant byte first, for `addrBytes` bytes (0 to 4).
- R6: When `dummyBytes` is nonzero, one dummy entry 0x00005100 | mode<<10 | cycles is sent. Here cycles = dummyBytes*8/width, the transmit and receive bits are clear, and an unsupported width counts as 1. When `dummyBytes` is zero the entry is omitted.
- R7: Lane widths 1, 2 and 4 map to modes 01, 10 and 11. Any other width maps to 01.
- R8: `dataDir` 01 means receive (bit 17) and 10 means transmit (bit 16). A data length from 1 to 255 gives one entry 0x5100 | mode<<10 | dir bit | length.
- R9: For a length above 255, one exponent entry (bit 9 and bit 8 set, immediate e) is sent for every set bit e at 8 or above, in ascending e. A non-exponent entry then carries the low byte, but only when that byte is nonzero.
- R10: In a receive operation the non-exponent remainder is rounded up to a multiple of ALIGN (4), and the low 8 bits of the rounded value are carried.
- R11: A zero data length, or `dataDir` of 00 or 11, produces no data entry.
- R12: `opDone` is high for exactly one cycle, the cycle after the deassert entry is accepted.
- R13: While `entryValid` is high and `entryReady` is low, `entry` holds its value and stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| descValid | input | 1 | Descriptor offered |
| descReady | output | 1 | Sequencer idle, descriptor taken on this cycle |
| opcode | input | 8 | Command opcode |
| cmdLanes | input | 3 | Opcode lane width |
| addrBytes | input | 3 | Address byte count (0..ADDR_W/8) |
| addrVal | input | ADDR_W | Address value |
| addrLanes | input | 3 | Address lane width |
| dummyBytes | input | DUMMY_W | Dummy byte count |
| dummyLanes | input | 3 | Dummy lane width |
| dataLen | input | LEN_W | Data byte count |
| dataDir | input | 2 | 01 receive, 10 transmit, else none |
| dataLanes | input | 3 | Data lane width |
| entryValid | output | 1 | Entry available |
| entryReady | input | 1 | Engine takes entry |
| entry | output | 32 | Command entry |
| opDone | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: a 32-bit address (up to four address bytes), a 16-bit length (exponents 8 to 15 reachable), 5-bit dummy counts and an alignment of 4. The 16-bit length makes multi-exponent splits reachable, along with splits that have no remainder and receive remainders that round past 255. The bench also applies pseudo-random backpressure on the entry output, so stall holding and the done timing are exercised under uneven acceptance.

// File: rtl/qspiseq_pkg.sv
package qspiseq_pkg;

  typedef enum logic [2:0] {
    K_IDLE  = 3'd0,
    K_CSON  = 3'd1,
    K_OPC   = 3'd2,
    K_ADDR  = 3'd3,
    K_DUMMY = 3'd4,
    K_DATA  = 3'd5,
    K_CSOFF = 3'd6
  } entryKind_e;

  typedef struct packed {
    entryKind_e kind;
    logic       load;
    logic       addrAdv;
    logic       dataAdv;
  } seqStrobe_t;

  localparam logic [31:0] F_XFER  = 32'h0000_0100;
  localparam logic [31:0] F_EXP   = 32'h0000_0200;
  localparam logic [31:0] F_CSLO  = 32'h0000_1000;
  localparam logic [31:0] F_BUSLO = 32'h0000_4000;
  localparam logic [31:0] F_TX    = 32'h0001_0000;
  localparam logic [31:0] F_RX    = 32'h0002_0000;
  localparam int unsigned MODE_LSB = 10;
  localparam logic [7:0] CS_HOLD = 8'd5;

  localparam logic [1:0] DIR_RX = 2'b01;
  localparam logic [1:0] DIR_TX = 2'b10;

  function automatic logic [1:0] laneMode(input logic [2:0] lanes);
    case (lanes)
      3'd2:    laneMode = 2'b10;
      3'd4:    laneMode = 2'b11;
      default: laneMode = 2'b01;
    endcase
  endfunction

  function automatic logic [1:0] laneShift(input logic [2:0] lanes);
    case (lanes)
      3'd2:    laneShift = 2'd1;
      3'd4:    laneShift = 2'd2;
      default: laneShift = 2'd0;
    endcase
  endfunction

  function automatic logic [31:0] modeField(input logic [1:0] m);
    modeField = 32'(m) << MODE_LSB;
  endfunction

endpackage

// File: rtl/qspi_seq_ctrl.sv
module qspi_seq_ctrl
  import qspiseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descValid,
  output logic       descReady,
  input  logic       entryReady,
  output logic       entryValid,
  output logic       opDone,
  input  logic       hasAddr,
  input  logic       addrLast,
  input  logic       hasDummy,
  input  logic       hasData,
  input  logic       dataLast,
  output seqStrobe_t strobe
);

  entryKind_e st, stNext;
  logic fire;
  entryKind_e postDummy, postAddr;

  assign entryValid = (st != K_IDLE);
  assign descReady  = (st == K_IDLE);
  assign fire       = entryValid && entryReady;

  assign postDummy = hasData ? K_DATA : K_CSOFF;
  assign postAddr  = hasDummy ? K_DUMMY : postDummy;

  always_comb begin
    stNext = st;
    case (st)
      K_IDLE:  if (descValid) stNext = K_CSON;
      K_CSON:  if (fire) stNext = K_OPC;
      K_OPC:   if (fire) stNext = hasAddr ? K_ADDR : postAddr;
      K_ADDR:  if (fire && addrLast) stNext = postAddr;
      K_DUMMY: if (fire) stNext = postDummy;
      K_DATA:  if (fire && dataLast) stNext = K_CSOFF;
      K_CSOFF: if (fire) stNext = K_IDLE;
      default: stNext = K_IDLE;
    endcase
  end

  always_comb begin
    strobe.kind    = st;
    strobe.load    = descReady && descValid;
    strobe.addrAdv = fire && (st == K_ADDR);
    strobe.dataAdv = fire && (st == K_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= K_IDLE;
      opDone <= 1'b0;
    end else begin
      st     <= stNext;
      opDone <= fire && (st == K_CSOFF);
    end
  end

endmodule

// File: rtl/qspi_seq_datapath.sv
module qspi_seq_datapath
  import qspiseq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned DUMMY_W = 5,
  parameter int unsigned ALIGN   = 4,
  parameter int unsigned ACNT_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [7:0]         opcode,
  input  logic [2:0]         cmdLanes,
  input  logic [ACNT_W-1:0]  addrBytes,
  input  logic [ADDR_W-1:0]  addrVal,
  input  logic [2:0]         addrLanes,
  input  logic [DUMMY_W-1:0] dummyBytes,
  input  logic [2:0]         dummyLanes,
  input  logic [LEN_W-1:0]   dataLen,
  input  logic [1:0]         dataDir,
  input  logic [2:0]         dataLanes,
  output logic [31:0]        entry,
  output logic               hasAddr,
  output logic               addrLast,
  output logic               hasDummy,
  output logic               hasData,
  output logic               dataLast
);

  localparam int unsigned DSCALE_W = DUMMY_W + 3;
  localparam logic [8:0]  ALIGN_M1 = 9'(ALIGN - 1);

  logic [7:0]         opcodeR;
  logic [1:0]         cmdModeR, addrModeR, dummyModeR, dataModeR;
  logic [ADDR_W-1:0]  addrR;
  logic [ACNT_W-1:0]  addrCnt;
  logic [7:0]         dummyCycR;
  logic [LEN_W-1:0]   remLen;
  logic [1:0]         dirR;

  logic [DSCALE_W-1:0] dummyScaled;
  logic [ADDR_W-1:0]   addrShifted;
  logic [7:0]          addrByte;
  logic [7:0]          expSel;
  logic                highNz;
  logic [LEN_W-1:0]    nextRem;
  logic [8:0]          rndSum;
  logic [7:0]          remImm;
  logic                isRx;
  logic [31:0]         selBase, dataBase;

  assign dummyScaled = {dummyBytes, 3'b000} >> laneShift(dummyLanes);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeR    <= '0;
      cmdModeR   <= 2'b01;
      addrModeR  <= 2'b01;
      dummyModeR <= 2'b01;
      dataModeR  <= 2'b01;
      addrR      <= '0;
      addrCnt    <= '0;
      dummyCycR  <= '0;
      remLen     <= '0;
      dirR       <= '0;
    end else if (strobe.load) begin
      opcodeR    <= opcode;
      cmdModeR   <= laneMode(cmdLanes);
      addrModeR  <= laneMode(addrLanes);
      dummyModeR <= laneMode(dummyLanes);
      dataModeR  <= laneMode(dataLanes);
      addrR      <= addrVal;
      addrCnt    <= addrBytes;
      dummyCycR  <= 8'(dummyScaled);
      remLen     <= dataLen;
      dirR       <= dataDir;
    end else begin
      if (strobe.addrAdv) addrCnt <= addrCnt - ACNT_W'(1);
      if (strobe.dataAdv) remLen  <= nextRem;
    end
  end

  // Address byte selection, most significant first
  assign addrShifted = addrR >> {addrCnt - ACNT_W'(1), 3'b000};
  assign addrByte    = addrShifted[7:0];
  assign hasAddr     = (addrCnt != '0);
  assign addrLast    = (addrCnt == ACNT_W'(1));
  assign hasDummy    = (dummyCycR != '0);

  // Lowest set bit at or above 8 drives the next exponent entry
  always_comb begin
    expSel = '0;
    for (int i = LEN_W - 1; i >= 8; i--) begin
      if (remLen[i]) expSel = 8'(i);
    end
  end

  assign highNz   = |remLen[LEN_W-1:8];
  assign nextRem  = highNz ? (remLen & ~(LEN_W'(1) << expSel)) : '0;
  assign dataLast = (nextRem == '0);
  assign isRx     = (dirR == DIR_RX);
  assign hasData  = ((dirR == DIR_RX) || (dirR == DIR_TX)) && (remLen != '0);

  assign rndSum = ({1'b0, remLen[7:0]} + ALIGN_M1) & ~ALIGN_M1;
  assign remImm = isRx ? rndSum[7:0] : remLen[7:0];

  assign selBase  = F_BUSLO | F_CSLO;
  assign dataBase = selBase | F_XFER | modeField(dataModeR) | (isRx ? F_RX : F_TX);

  always_comb begin
    case (strobe.kind)
      K_CSON:  entry = selBase | modeField(2'b01) | 32'(CS_HOLD);
      K_OPC:   entry = selBase | F_TX | modeField(cmdModeR) | 32'(opcodeR);
      K_ADDR:  entry = selBase | F_TX | modeField(addrModeR) | 32'(addrByte);
      K_DUMMY: entry = selBase | F_XFER | modeField(dummyModeR) | 32'(dummyCycR);
      K_DATA:  entry = highNz ? (dataBase | F_EXP | 32'(expSel))
                              : (dataBase | 32'(remImm));
      K_CSOFF: entry = F_BUSLO | 32'(CS_HOLD);
      default: entry = '0;
    endcase
  end

endmodule

// File: rtl/qspi_op_sequencer.sv
module qspi_op_sequencer
  import qspiseq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned DUMMY_W = 5,
  parameter int unsigned ALIGN   = 4,
  localparam int unsigned ADDR_BYTES = ADDR_W / 8,
  localparam int unsigned ACNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               descValid,
  output logic               descReady,
  input  logic [7:0]         opcode,
  input  logic [2:0]         cmdLanes,
  input  logic [ACNT_W-1:0]  addrBytes,
  input  logic [ADDR_W-1:0]  addrVal,
  input  logic [2:0]         addrLanes,
  input  logic [DUMMY_W-1:0] dummyBytes,
  input  logic [2:0]         dummyLanes,
  input  logic [LEN_W-1:0]   dataLen,
  input  logic [1:0]         dataDir,
  input  logic [2:0]         dataLanes,
  output logic               entryValid,
  input  logic               entryReady,
  output logic [31:0]        entry,
  output logic               opDone
);

  seqStrobe_t strobe;
  logic hasAddr, addrLast, hasDummy, hasData, dataLast;

  qspi_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .descValid  (descValid),
    .descReady  (descReady),
    .entryReady (entryReady),
    .entryValid (entryValid),
    .opDone     (opDone),
    .hasAddr    (hasAddr),
    .addrLast   (addrLast),
    .hasDummy   (hasDummy),
    .hasData    (hasData),
    .dataLast   (dataLast),
    .strobe     (strobe)
  );

  qspi_seq_datapath #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .DUMMY_W (DUMMY_W),
    .ALIGN   (ALIGN),
    .ACNT_W  (ACNT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opcode     (opcode),
    .cmdLanes   (cmdLanes),
    .addrBytes  (addrBytes),
    .addrVal    (addrVal),
    .addrLanes  (addrLanes),
    .dummyBytes (dummyBytes),
    .dummyLanes (dummyLanes),
    .dataLen    (dataLen),
    .dataDir    (dataDir),
    .dataLanes  (dataLanes),
    .entry      (entry),
    .hasAddr    (hasAddr),
    .addrLast   (addrLast),
    .hasDummy   (hasDummy),
    .hasData    (hasData),
    .dataLast   (dataLast)
  );

endmodule

// File: rtl/qspi_seq_checker.sv
module qspi_seq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        descReady,
  input logic        entryValid,
  input logic        entryReady,
  input logic [31:0] entry,
  input logic        opDone
);

  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryValid && !entryReady |=> entryValid && $stable(entry));

  // R1
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    descReady |-> !entryValid);

  // R12
  done_after_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> $past(entryValid && entryReady && (entry == 32'h0000_4005)));

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

  // R9
  exp_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryValid && entry[9] |-> entry[8] && (entry[7:0] >= 8'd8));

  // R3
  mode_zero_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryValid && (entry[11:10] == 2'b00) |-> (entry == 32'h0000_4005));

endmodule

bind qspi_op_sequencer qspi_seq_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .descReady  (descReady),
  .entryValid (entryValid),
  .entryReady (entryReady),
  .entry      (entry),
  .opDone     (opDone)
);

// File: tb/qspi_op_sequencer_tb_top.sv
module qspi_op_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        descValid = 1'b0;
  logic        descReady;
  logic [7:0]  opcode = '0;
  logic [2:0]  cmdLanes = 3'd1;
  logic [2:0]  addrBytes = '0;
  logic [31:0] addrVal = '0;
  logic [2:0]  addrLanes = 3'd1;
  logic [4:0]  dummyBytes = '0;
  logic [2:0]  dummyLanes = 3'd1;
  logic [15:0] dataLen = '0;
  logic [1:0]  dataDir = '0;
  logic [2:0]  dataLanes = 3'd1;
  logic        entryValid;
  logic        entryReady = 1'b0;
  logic [31:0] entry;
  logic        opDone;

  int checks = 0;
  int fails = 0;
  int doneCnt = 0;
  bit expectDone = 0;
  bit readyAll = 1;
  bit stallSeen = 0;
  logic [31:0] stallVal = '0;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qspi_op_sequencer dut_i (
    .clk(clk), .rstN(rstN), .descValid(descValid), .descReady(descReady),
    .opcode(opcode), .cmdLanes(cmdLanes), .addrBytes(addrBytes), .addrVal(addrVal),
    .addrLanes(addrLanes), .dummyBytes(dummyBytes), .dummyLanes(dummyLanes),
    .dataLen(dataLen), .dataDir(dataDir), .dataLanes(dataLanes),
    .entryValid(entryValid), .entryReady(entryReady), .entry(entry), .opDone(opDone)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modeOf(input logic [2:0] w);
    if (w == 3'd2) return 32'h800;
    if (w == 3'd4) return 32'hC00;
    return 32'h400;
  endfunction

  function automatic int widthOf(input logic [2:0] w);
    if (w == 3'd2 || w == 3'd4) return int'(w);
    return 1;
  endfunction

  task automatic pushExp(input logic [31:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // Backpressure driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      entryReady = readyAll ? 1'b1 : (lfsr[0] | lfsr[3]);
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (expectDone) begin
        chk(opDone == 1'b1, "R12 done pulse", 32'(opDone), 32'd1);
        expectDone = 0;
        doneCnt++;
      end else if (opDone) begin
        chk(1'b0, "R12 stray done", 32'(opDone), 32'd0);
      end
      if (stallSeen) begin
        chk(entryValid && entry == stallVal, "R13 held entry", entry, stallVal);
      end
      stallSeen = entryValid && !entryReady;
      stallVal  = entry;
      if (entryValid && entryReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 unexpected entry", entry, 32'h0);
        end else begin
          automatic logic [31:0] e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          chk(entry == e, t, entry, e);
          if (e == 32'h0000_4005) expectDone = 1;
        end
      end
    end
  end

  task automatic runOp(input logic [7:0] op, input logic [2:0] cl,
                       input logic [2:0] ab, input logic [31:0] av, input logic [2:0] al,
                       input logic [4:0] db, input logic [2:0] dl,
                       input logic [15:0] len, input logic [1:0] dir, input logic [2:0] dwl,
                       input bit poke);
    int startDone;
    int rem;
    logic [31:0] base;
    // expected stream built from the requirements
    pushExp(32'h0000_5405, "R2/R3 cs assert");
    pushExp(32'h0001_5000 | modeOf(cl) | 32'(op), "R4/R7 opcode");
    for (int i = int'(ab) - 1; i >= 0; i--)
      pushExp(32'h0001_5000 | modeOf(al) | ((av >> (8 * i)) & 32'hFF), "R5 address byte");
    if (db != 0)
      pushExp(32'h0000_5100 | modeOf(dl) | 32'((int'(db) * 8) / widthOf(dl)), "R6 dummy");
    if ((dir == 2'b01 || dir == 2'b10) && len != 0) begin
      rem  = int'(len);
      base = 32'h0000_5100 | modeOf(dwl) | (dir == 2'b01 ? 32'h2_0000 : 32'h1_0000);
      for (int e = 8; e < 16; e++) begin
        if (rem > 255 && ((rem >> e) & 1) == 1) begin
          pushExp(base | 32'h200 | 32'(e), "R9 exponent");
          rem = rem - (1 << e);
        end
      end
      if (rem != 0) begin
        if (dir == 2'b01) pushExp(base | 32'((((rem + 3) / 4) * 4) & 255), "R10 rx remainder");
        else              pushExp(base | 32'(rem), "R8 tx remainder");
      end
    end
    pushExp(32'h0000_4005, "R2/R3 cs deassert");

    startDone = doneCnt;
    @(posedge clk); #1;
    opcode = op; cmdLanes = cl; addrBytes = ab; addrVal = av; addrLanes = al;
    dummyBytes = db; dummyLanes = dl; dataLen = len; dataDir = dir; dataLanes = dwl;
    descValid = 1'b1;
    @(negedge clk);
    chk(descReady == 1'b1, "R1 ready when idle", 32'(descReady), 32'd1);
    @(posedge clk); #1;
    if (poke) begin
      // R1: a second descriptor while busy must be ignored
      opcode = 8'h5A; addrBytes = 3'd2; dataLen = 16'd7; dataDir = 2'b10;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk(descReady == 1'b0, "R1 busy not ready", 32'(descReady), 32'd0);
        @(posedge clk); #1;
      end
    end
    descValid = 1'b0;
    while (doneCnt == startDone) @(negedge clk);
    chk(expQ.size() == 0, "R2 all entries seen", 32'(expQ.size()), 32'd0);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(entryValid == 1'b0, "R1 reset entryValid", 32'(entryValid), 32'd0);
    chk(descReady == 1'b1, "R1 reset descReady", 32'(descReady), 32'd1);
    chk(opDone == 1'b0, "R1 reset opDone", 32'(opDone), 32'd0);

    // command only, no data (R11 dir none)
    runOp(8'h9F, 3'd1, 3'd0, 32'h0, 3'd1, 5'd0, 3'd1, 16'd0, 2'b00, 3'd1, 1);
    // quad read: 3 address bytes, 3 dummy bytes at 4 lanes, 16 bytes rx
    runOp(8'hEB, 3'd1, 3'd3, 32'h0012_3456, 3'd4, 5'd3, 3'd4, 16'd16, 2'b01, 3'd4, 0);
    readyAll = 0;
    // tx 300 bytes dual: exp 8 + 44
    runOp(8'h32, 3'd2, 3'd3, 32'h00AB_CDEF, 3'd2, 5'd0, 3'd1, 16'd300, 2'b10, 3'd2, 0);
    // rx 0x1203: exp 9, exp 12, remainder 3 rounds to 4 (R10)
    runOp(8'h6C, 3'd1, 3'd4, 32'hDEAD_BEEF, 3'd1, 5'd1, 3'd2, 16'h1203, 2'b01, 3'd4, 1);
    // rx 253 rounds to 256, low byte 0 (R10)
    runOp(8'h03, 3'd1, 3'd3, 32'h0000_0100, 3'd1, 5'd0, 3'd1, 16'd253, 2'b01, 3'd1, 0);
    // rx 0x300: two exponents, no remainder (R9)
    runOp(8'h0B, 3'd1, 3'd3, 32'h0001_0203, 3'd1, 5'd1, 3'd1, 16'h0300, 2'b01, 3'd1, 0);
    // unsupported widths fall back to single lane (R7, R6)
    runOp(8'h77, 3'd3, 3'd1, 32'h0000_00C3, 3'd0, 5'd2, 3'd5, 16'd9, 2'b10, 3'd7, 0);
    // zero length and direction 11 produce no data entry (R11)
    runOp(8'h06, 3'd1, 3'd0, 32'h0, 3'd1, 5'd0, 3'd1, 16'd0, 2'b10, 3'd1, 0);
    runOp(8'h05, 3'd4, 3'd0, 32'h0, 3'd1, 5'd4, 3'd2, 16'd10, 2'b11, 3'd1, 0);
    // full length tx, all exponents 8..15 plus 255 (R9, R8)
    runOp(8'h02, 3'd1, 3'd4, 32'h1234_5678, 3'd4, 5'd31, 3'd1, 16'hFFFF, 2'b10, 3'd4, 0);

    repeat (4) @(negedge clk);
    chk(entryValid == 1'b0, "R1 idle after ops", 32'(entryValid), 32'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired R2 actual=0x%08h expected=0x%08h", 32'(expQ.size()), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule